// File: doc/BRIEF.md
# Dual-Bank Swappable Vector RAM

This block stores interrupt vectors in two physical RAM banks so that a firmware image can be replaced while the system runs. One bank is active and answers a fixed address window. Vector fetches and normal accesses use that window. The other bank is inactive and answers a second fixed window. New firmware writes its vector addresses there ahead of the switchover.

A single write of 1 to the swap control bit exchanges the roles of the two banks at the next clock edge. A status output reports which physical bank currently serves the active window. The swap cannot be undone except by reset.

Every word is held twice: once in a primary bank and once in a redundant bank. The redundant banks swap in lockstep with the primary banks. Each stored word carries an even parity bit computed over the data XORed with the word's offset inside its window. This lets both data corruption and a word read back from the wrong location show up. Every read compares the primary word with the redundant word and checks both parity bits. A failure produces a one-cycle error pulse and sets a sticky error flag.

Top module: `swap_vector_ram`

## Requirements
- R1: After reset, `swapped` is 0, `err_sticky` and `err_pulse` are 0 and `rvalid` is 0. Physical bank 0 serves the active window.
- R2: Active window: a request whose word address lies in 0x0000_0D00..0x0000_0EFF reaches the currently active bank. A read returns its data on `rdata` with `rvalid` high in the cycle after the request edge.
- R3: Inactive window: a request in 0x0100_0900..0x0100_0AFF reaches the other bank, using the same offset (address minus window base) and the same one-cycle read latency.
- R4: A cycle with `swap_wr` = 1 and `swap_bit` = 1 sets `swapped` from the next edge onwards. From then on, the bank previously reached through the inactive window is reached through the active window, and the reverse holds too.
- R5: `swapped` is cleared only by reset. Further swap writes, whether of 1 or of 0, change neither `swapped` nor the bank mapping.
- R6: A write to the active window in the same cycle as a swap command lands in the bank that was active before the swap. After the swap, that data is seen through the inactive window.
- R7: Each write also stores the word in a redundant bank that follows the same mapping. A read whose primary and redundant words differ is an error. Driving `fi_red` = 1 with a write inverts bit 0 of the redundant copy only.
- R8: Each stored word keeps even parity over (data XOR window offset), and a read whose stored parity fails is an error. Driving `fi_pri` = 1 with a write inverts bit 0 of the primary copy after its parity is formed. Its later read returns the inverted data and flags an error.
- R9: An error is reported by `err_pulse` = 1 in the same cycle as the read data, for that cycle only. It also sets `err_sticky`, which stays 1 until reset.
- R10: A request outside both windows writes nothing. A read there gives `rvalid` = 1, `rdata` = 0 and no error one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Word address |
| wdata | input | 16 | Write data |
| fi_pri | input | 1 | Fault injection: invert bit 0 of the primary copy on this write |
| fi_red | input | 1 | Fault injection: invert bit 0 of the redundant copy on this write |
| swap_wr | input | 1 | Write strobe for the swap control bit |
| swap_bit | input | 1 | Value written to the swap control bit |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| swapped | output | 1 | Swap status: 1 = physical bank 1 serves the active window |
| err_pulse | output | 1 | One-cycle error indication with the failing read data |
| err_sticky | output | 1 | Latched error flag, cleared by reset |

## Verification
Read results appear one cycle after the request edge. `rdata`, `rvalid` and `err_pulse` all become valid together, and `err_sticky` already includes that read's error in the same cycle. `swapped` changes at the edge that samples the swap command. A write issued in that same cycle is routed using the mapping from before that edge.

The bench drives inputs on the falling edge and advances its behavioural model at the rising edge, using the pre-edge mapping. It compares every output on the following falling edge, so each result is sampled exactly one register stage after its stimulus.

// File: rtl/swap_vector_ram.sv
module swap_vector_ram #(
  parameter int          DW         = 16,
  parameter int          AW         = 32,
  parameter int          WORDS      = 512,
  parameter logic [31:0] ACT_BASE   = 32'h0000_0D00,
  parameter logic [31:0] INACT_BASE = 32'h0100_0900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          fi_pri,
  input  logic          fi_red,
  input  logic          swap_wr,
  input  logic          swap_bit,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          swapped,
  output logic          err_pulse,
  output logic          err_sticky
);
  localparam int OW = $clog2(WORDS);

  logic [DW:0] pri_mem [2][WORDS];
  logic [DW:0] red_mem [2][WORDS];

  logic          sel_q;
  logic          rvalid_q, hit_q, sticky_q;
  logic [OW-1:0] off_q;
  logic [DW:0]   pri_q, red_q;

  logic [AW-1:0] act_rel, ina_rel;
  logic          hit_act, hit_ina, hit;
  logic [OW-1:0] off;
  logic          bank;
  logic          par_w;
  logic [DW-1:0] flip_p, flip_r;

  assign act_rel = addr - AW'(ACT_BASE);
  assign ina_rel = addr - AW'(INACT_BASE);
  assign hit_act = (addr >= AW'(ACT_BASE))   && (act_rel < AW'(WORDS));
  assign hit_ina = (addr >= AW'(INACT_BASE)) && (ina_rel < AW'(WORDS));
  assign hit     = hit_act | hit_ina;
  assign off     = hit_act ? act_rel[OW-1:0] : ina_rel[OW-1:0];
  assign bank    = hit_act ? sel_q : ~sel_q;
  assign par_w   = (^wdata) ^ (^off);
  assign flip_p  = {{(DW-1){1'b0}}, fi_pri};
  assign flip_r  = {{(DW-1){1'b0}}, fi_red};

  always_ff @(posedge clk) begin
    if (req && we && hit) begin
      pri_mem[bank][off] <= {par_w, wdata ^ flip_p};
      red_mem[bank][off] <= {par_w, wdata ^ flip_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      rvalid_q <= 1'b0;
      hit_q    <= 1'b0;
      off_q    <= '0;
      pri_q    <= '0;
      red_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (swap_wr && swap_bit) sel_q <= 1'b1;
      rvalid_q <= req && !we;
      hit_q    <= req && !we && hit;
      off_q    <= off;
      if (req && !we && hit) begin
        pri_q <= pri_mem[bank][off];
        red_q <= red_mem[bank][off];
      end
      if (err_pulse) sticky_q <= 1'b1;
    end
  end

  logic pri_bad, red_bad, mism;
  assign pri_bad = pri_q[DW] ^ (^pri_q[DW-1:0]) ^ (^off_q);
  assign red_bad = red_q[DW] ^ (^red_q[DW-1:0]) ^ (^off_q);
  assign mism    = pri_q != red_q;

  assign rdata      = hit_q ? pri_q[DW-1:0] : '0;
  assign rvalid     = rvalid_q;
  assign swapped    = sel_q;
  assign err_pulse  = hit_q && (pri_bad || red_bad || mism);
  assign err_sticky = sticky_q | err_pulse;
endmodule

// File: rtl/swap_vector_ram_chk.sv
module swap_vector_ram_chk #(
  parameter int          DW         = 16,
  parameter int          AW         = 32,
  parameter int          WORDS      = 512,
  parameter logic [31:0] ACT_BASE   = 32'h0000_0D00,
  parameter logic [31:0] INACT_BASE = 32'h0100_0900
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          swap_wr,
  input logic          swap_bit,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          swapped,
  input logic          err_pulse,
  input logic          err_sticky
);
  logic outside;
  assign outside = !((addr >= AW'(ACT_BASE)   && addr < AW'(ACT_BASE) + AW'(WORDS)) ||
                     (addr >= AW'(INACT_BASE) && addr < AW'(INACT_BASE) + AW'(WORDS)));

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we |=> rvalid);
  a_r1_no_spurious_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_wr && swap_bit) && !swapped |=> !swapped);
  a_r4_swap_takes: assert property (@(posedge clk) disable iff (!rst_n)
    swap_wr && swap_bit |=> swapped);
  a_r5_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    swapped |=> swapped);
  a_r9_pulse_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> rvalid && err_sticky);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && outside |=> rvalid && rdata == '0 && !err_pulse);
endmodule

bind swap_vector_ram swap_vector_ram_chk #(
  .DW(DW), .AW(AW), .WORDS(WORDS), .ACT_BASE(ACT_BASE), .INACT_BASE(INACT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
  .swap_wr(swap_wr), .swap_bit(swap_bit), .rdata(rdata), .rvalid(rvalid),
  .swapped(swapped), .err_pulse(err_pulse), .err_sticky(err_sticky)
);

// File: tb/tb_swap_vector_ram.sv
module tb_swap_vector_ram;
  localparam logic [31:0] ACT = 32'h0000_0D00;
  localparam logic [31:0] INA = 32'h0100_0900;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, fi_pri = 0, fi_red = 0, swap_wr = 0, swap_bit = 0;
  logic [31:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid, swapped, err_pulse, err_sticky;

  always #10 clk = ~clk;

  swap_vector_ram dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .fi_pri(fi_pri), .fi_red(fi_red), .swap_wr(swap_wr), .swap_bit(swap_bit),
    .rdata(rdata), .rvalid(rvalid), .swapped(swapped),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  int tests = 0, fails = 0;
  int m_data [2][512];
  bit m_fp [2][512];
  bit m_fr [2][512];
  bit m_sel = 0, m_sticky = 0;
  bit e_rvalid = 0, e_err = 0;
  int e_rdata = 0;

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rvalid", int'(rvalid), int'(e_rvalid));
    if (e_rvalid) chk(tag, "rdata", int'(rdata), e_rdata);
    chk(tag, "swapped", int'(swapped), int'(m_sel));
    chk(tag, "err_pulse", int'(err_pulse), int'(e_err));
    chk(tag, "err_sticky", int'(err_sticky), int'(m_sticky));
  endtask

  task automatic cyc(string tag, bit r, bit w, logic [31:0] a, logic [15:0] d,
                     bit sw = 0, bit sb = 0, bit fp = 0, bit fr = 0);
    int off, b;
    bit in_a, in_i;
    req = r; we = w; addr = a; wdata = d; swap_wr = sw; swap_bit = sb;
    fi_pri = fp; fi_red = fr;
    @(posedge clk);
    in_a = a >= ACT && a < ACT + 512;
    in_i = a >= INA && a < INA + 512;
    off  = in_a ? int'(a - ACT) : int'(a - INA);
    b    = in_a ? int'(m_sel) : int'(!m_sel);
    e_rvalid = r && !w;
    e_err = 0;
    e_rdata = 0;
    if (r && !w && (in_a || in_i)) begin
      e_rdata = m_data[b][off] ^ int'(m_fp[b][off]);
      e_err = m_fp[b][off] | m_fr[b][off];
    end
    if (r && w && (in_a || in_i)) begin
      m_data[b][off] = int'(d);
      m_fp[b][off] = fp;
      m_fr[b][off] = fr;
    end
    if (sw && sb) m_sel = 1;
    if (e_err) m_sticky = 1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset;
    req = 0; we = 0; swap_wr = 0; swap_bit = 0; fi_pri = 0; fi_red = 0;
    rst_n = 0;
    m_sel = 0; m_sticky = 0; e_rvalid = 0; e_err = 0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    #4ms;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 / R3: fill both windows and read back
    for (int i = 0; i < 8; i++) cyc("R2", 1, 1, ACT + i, 16'h1000 + 16'(i * 3));
    for (int i = 0; i < 8; i++) cyc("R3", 1, 1, INA + i, 16'hA500 ^ 16'(i * 7));
    cyc("R2", 1, 1, ACT + 511, 16'hBEEF);
    cyc("R3", 1, 1, INA + 511, 16'h5A5A);
    for (int i = 0; i < 8; i++) cyc("R2", 1, 0, ACT + i, 0);
    for (int i = 0; i < 8; i++) cyc("R3", 1, 0, INA + i, 0);
    cyc("R2", 1, 0, ACT + 511, 0);
    cyc("R3", 1, 0, INA + 511, 0);
    // R10: outside the windows
    cyc("R10", 1, 1, ACT + 512, 16'hFFFF);
    cyc("R10", 1, 1, ACT - 1, 16'hFFFF);
    cyc("R10", 1, 1, INA - 1, 16'hFFFF);
    cyc("R10", 1, 1, INA + 512, 16'hFFFF);
    cyc("R10", 1, 0, ACT + 512, 0);
    cyc("R10", 1, 0, 32'h0000_0000, 0);
    cyc("R10", 1, 0, ACT + 511, 0);
    cyc("R10", 1, 0, INA, 0);
    cyc("R10", 1, 0, INA + 511, 0);
    // R6 / R4: swap with a simultaneous active-window write
    cyc("R6", 1, 1, ACT + 5, 16'h6666, 1, 1);
    cyc("R6", 1, 0, INA + 5, 0);
    cyc("R4", 1, 0, ACT + 0, 0);
    cyc("R4", 1, 0, INA + 0, 0);
    cyc("R4", 1, 0, ACT + 511, 0);
    // R5: further swap writes have no effect
    cyc("R5", 0, 0, 0, 0, 1, 0);
    cyc("R5", 1, 0, ACT + 1, 0, 1, 1);
    cyc("R5", 1, 0, INA + 1, 0, 1, 0);
    // R7: redundant mismatch
    cyc("R7", 1, 1, ACT + 10, 16'h0F0F, 0, 0, 0, 1);
    cyc("R7", 1, 0, ACT + 10, 0);
    cyc("R9", 1, 0, ACT + 1, 0);
    cyc("R9", 0, 0, 0, 0);
    // R1 again, then R8: primary corruption caught by parity
    do_reset();
    cyc("R1", 1, 0, ACT + 2, 0);
    cyc("R8", 1, 1, INA + 20, 16'h1234, 0, 0, 1, 0);
    cyc("R8", 1, 0, INA + 20, 0);
    cyc("R9", 1, 0, INA + 3, 0);
    do_reset();
    // Mixed traffic
    for (int i = 0; i < 8; i++) cyc("R2", 1, 1, ACT + i, 16'(i));
    for (int i = 0; i < 8; i++) cyc("R3", 1, 1, INA + i, 16'(i + 100));
    for (int n = 0; n < 400; n++) begin
      bit ww = $urandom_range(0, 2) == 0;
      bit win = $urandom_range(0, 1) == 1;
      int o = $urandom_range(0, 7);
      bit sw = (n == 200);
      cyc(win ? "R2" : "R3", $urandom_range(0, 3) != 0, ww, (win ? ACT : INA) + o,
          16'($urandom), sw, sw);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule